// File: doc/BRIEF.md
# Thermal Threshold Alarm with Hysteresis

This block sits behind a temperature sensor's sample filter. It watches every new filtered code and keeps three alarm states. The first alarm rises when the reading climbs too high, the second when it falls too low, and the third guards against overheating. The high and low alarms each have a trip level and a separate release level. The gap between the two levels gives hysteresis, so a reading that sits near a limit does not make the alarm toggle. An alarm raises one sticky event flag when it becomes active and another when it is released.

The overheat alarm has a single threshold. A 4-bit action key chooses what it does: request a system reset, raise only the interrupt, or do nothing beyond setting its flag. Software sets the thresholds through a small word-wide register port, enables interrupt sources, and clears flags by writing ones to them. Comparison happens only while the channel runs in periodic sampling mode. The codes made of all zeros and all ones are dropped as broken readings.

Top module: `thermal_alarm`

## Requirements
- R1: After reset, all flags, `irq` and `resetReq` are 0 and all enables are 0. The high config reads trip level HI_TRIG_RST with release level HI_TRIG_RST-3. The low config reads LO_TRIG_RST with release LO_TRIG_RST+3. The overheat config reads OTP_RST.
- R2: Register layout, word address on `regAddr`:
  - 0 is the high config and 1 is the low config. In each, bit 31 is the enable, bits 27:16 the release level and bits 11:0 the trip level.
  - 2 is the overheat config, with bit 31 the enable and bits 11:0 the threshold.
  - 3 is control. Bits 28:24 are the flags (24 high-valid, 25 high-removed, 26 low-valid, 27 low-removed, 28 overheat), bits 15:12 the action key and bits 11:8 the interrupt enables for flags 24..27.
  - Unlisted bits read 0.
- R3: With the high alarm enabled and inactive, an accepted code >= the trip level makes it active and sets flag 24 once. Further high codes set nothing more.
- R4: An active high alarm is released, setting flag 25, only by an accepted code <= the release level. Codes between release and trip change nothing.
- R5: With the low alarm enabled, an accepted code <= trip while inactive sets flag 26 and makes it active. A code >= release while active sets flag 27 and makes it inactive.
- R6: With overheat enabled, an accepted code >= threshold while not over sets flag 28 once. The alarm re-arms only after an accepted code below the threshold.
- R7: With key 0xA, each overheat event gives a one-cycle `resetReq` pulse and flag 28 does not drive `irq`. With key 0x5, flag 28 drives `irq` and no reset is requested. With any other key, neither happens.
- R8: `irq` is the OR of flags 24..27, each gated by its enable bit 8..11, plus flag 28 when the key is 0x5. It follows flag and enable changes.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it. A flag set by an event in the same cycle as its clear stays set.
- R10: Samples arriving while `periodMode` is 0 change no alarm state and set no flag.
- R11: Codes 0 and 4095 change no alarm state and set no flag.
- R12: Clearing an alarm's enable drops its active state without raising an event. After re-enabling, the next qualifying code raises the valid event again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| periodMode | input | 1 | Channel runs in periodic sampling mode |
| sampleValid | input | 1 | New filtered code this cycle |
| sampleCode | input | CODE_W (12) | Filtered sensor code |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| irq | output | 1 | Interrupt request |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
Each alarm is driven with code sequences that walk across its trip level, sit inside the hysteresis band, and then cross the release level. This separates a correct two-level comparator from one that uses a single level or re-fires while it is already active. The overheat path runs the same crossing under three key values, which shows whether the action decode routes the event to reset, to interrupt or to neither. Broken codes, non-periodic samples and enable toggling are aimed at thresholds they would trip, so a design that ignores the qualifiers shows a flag. A write-one-to-clear issued in the same cycle as an event checks that the set takes priority.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;

  typedef enum logic [1:0] {
    ADDR_HIGH = 2'd0,
    ADDR_LOW  = 2'd1,
    ADDR_OTP  = 2'd2,
    ADDR_CTRL = 2'd3
  } regAddrE;

  localparam int CFG_EN_BIT = 31;
  localparam int REL_LSB    = 16;
  localparam int FLAG_LSB   = 24;
  localparam int KEY_LSB    = 12;
  localparam int IE_LSB     = 8;
  localparam int NUM_FLAGS  = 5;
  localparam int NUM_IE     = 4;
  localparam int KEY_W      = 4;

  localparam logic [KEY_W-1:0] KEY_RESET = 4'hA;
  localparam logic [KEY_W-1:0] KEY_IRQ   = 4'h5;

  // control -> datapath write strobes
  typedef struct packed {
    logic wrHigh;
    logic wrLow;
    logic wrOtp;
  } cfgWrT;

  // datapath -> control comparison results
  typedef struct packed {
    logic highEn;
    logic lowEn;
    logic otpEn;
    logic highTrip;
    logic highRel;
    logic lowTrip;
    logic lowRel;
    logic otpTrip;
  } cmpT;

endpackage

// File: rtl/thermal_alarm_dp.sv
module thermal_alarm_dp
  import thermal_alarm_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int HYST        = 3,
  parameter int HI_TRIG_RST = 3000,
  parameter int LO_TRIG_RST = 500,
  parameter int OTP_RST     = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgWrT             cfgWr,
  input  logic [31:0]       wrData,
  input  logic [CODE_W-1:0] code,
  output cmpT               cmp,
  output logic [31:0]       highCfgRd,
  output logic [31:0]       lowCfgRd,
  output logic [31:0]       otpCfgRd
);

  localparam logic [CODE_W-1:0] HI_TRIG_INIT = CODE_W'(HI_TRIG_RST);
  localparam logic [CODE_W-1:0] HI_REL_INIT  = CODE_W'(HI_TRIG_RST - HYST);
  localparam logic [CODE_W-1:0] LO_TRIG_INIT = CODE_W'(LO_TRIG_RST);
  localparam logic [CODE_W-1:0] LO_REL_INIT  = CODE_W'(LO_TRIG_RST + HYST);
  localparam logic [CODE_W-1:0] OTP_INIT     = CODE_W'(OTP_RST);

  logic              highEn, lowEn, otpEn;
  logic [CODE_W-1:0] highTrig, highRel, lowTrig, lowRel, otpThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highEn   <= 1'b0;
      highTrig <= HI_TRIG_INIT;
      highRel  <= HI_REL_INIT;
    end else if (cfgWr.wrHigh) begin
      highEn   <= wrData[CFG_EN_BIT];
      highTrig <= wrData[CODE_W-1:0];
      highRel  <= wrData[REL_LSB +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowEn   <= 1'b0;
      lowTrig <= LO_TRIG_INIT;
      lowRel  <= LO_REL_INIT;
    end else if (cfgWr.wrLow) begin
      lowEn   <= wrData[CFG_EN_BIT];
      lowTrig <= wrData[CODE_W-1:0];
      lowRel  <= wrData[REL_LSB +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otpEn  <= 1'b0;
      otpThr <= OTP_INIT;
    end else if (cfgWr.wrOtp) begin
      otpEn  <= wrData[CFG_EN_BIT];
      otpThr <= wrData[CODE_W-1:0];
    end
  end

  always_comb begin
    cmp.highEn   = highEn;
    cmp.lowEn    = lowEn;
    cmp.otpEn    = otpEn;
    cmp.highTrip = (code >= highTrig);
    cmp.highRel  = (code <= highRel);
    cmp.lowTrip  = (code <= lowTrig);
    cmp.lowRel   = (code >= lowRel);
    cmp.otpTrip  = (code >= otpThr);
  end

  assign highCfgRd = (32'(highEn) << CFG_EN_BIT) | (32'(highRel) << REL_LSB) | 32'(highTrig);
  assign lowCfgRd  = (32'(lowEn) << CFG_EN_BIT) | (32'(lowRel) << REL_LSB) | 32'(lowTrig);
  assign otpCfgRd  = (32'(otpEn) << CFG_EN_BIT) | 32'(otpThr);

  AST_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWr.wrHigh) |-> highCfgRd[CODE_W-1:0] == $past(wrData[CODE_W-1:0])) // R2
    else $error("high trip level not written");

  AST_OTP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWr.wrOtp) |-> otpCfgRd[CFG_EN_BIT] == $past(wrData[CFG_EN_BIT])) // R2
    else $error("overheat enable not written");

endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodMode,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  cmpT               cmp,
  input  logic [31:0]       highCfgRd,
  input  logic [31:0]       lowCfgRd,
  input  logic [31:0]       otpCfgRd,
  output cfgWrT             cfgWr,
  output logic [31:0]       regRdData,
  output logic              irq,
  output logic              resetReq
);

  localparam logic [CODE_W-1:0] CODE_ALL_ONES = '1;

  regAddrE addrE;
  logic    ctrlWr;
  logic    codeOk, take;

  logic highAct, lowAct, otpAct;
  logic highOn, highOff, lowOn, lowOff, otpOn;

  logic [NUM_FLAGS-1:0] flags, evt, clr;
  logic [KEY_W-1:0]     keyReg;
  logic [NUM_IE-1:0]    ieReg;

  // register write decode
  always_comb begin
    addrE       = regAddrE'(regAddr);
    cfgWr.wrHigh = regWrEn && (addrE == ADDR_HIGH);
    cfgWr.wrLow  = regWrEn && (addrE == ADDR_LOW);
    cfgWr.wrOtp  = regWrEn && (addrE == ADDR_OTP);
    ctrlWr       = regWrEn && (addrE == ADDR_CTRL);
  end

  // sample qualification
  assign codeOk = (sampleCode != '0) && (sampleCode != CODE_ALL_ONES);
  assign take   = sampleValid && periodMode && codeOk;

  // alarm events
  always_comb begin
    highOn  = take && cmp.highEn && !highAct && cmp.highTrip;
    highOff = take && cmp.highEn &&  highAct && cmp.highRel;
    lowOn   = take && cmp.lowEn  && !lowAct  && cmp.lowTrip;
    lowOff  = take && cmp.lowEn  &&  lowAct  && cmp.lowRel;
    otpOn   = take && cmp.otpEn  && !otpAct  && cmp.otpTrip;
    evt     = {otpOn, lowOff, lowOn, highOff, highOn};
    clr     = ctrlWr ? regWrData[FLAG_LSB +: NUM_FLAGS] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highAct <= 1'b0;
    end else if (!cmp.highEn) begin
      highAct <= 1'b0;
    end else if (highOn) begin
      highAct <= 1'b1;
    end else if (highOff) begin
      highAct <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowAct <= 1'b0;
    end else if (!cmp.lowEn) begin
      lowAct <= 1'b0;
    end else if (lowOn) begin
      lowAct <= 1'b1;
    end else if (lowOff) begin
      lowAct <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otpAct <= 1'b0;
    end else if (!cmp.otpEn) begin
      otpAct <= 1'b0;
    end else if (otpOn) begin
      otpAct <= 1'b1;
    end else if (take && !cmp.otpTrip) begin
      otpAct <= 1'b0;
    end
  end

  // flags, control fields, reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags    <= '0;
      keyReg   <= '0;
      ieReg    <= '0;
      resetReq <= 1'b0;
    end else begin
      flags    <= (flags & ~clr) | evt;
      resetReq <= otpOn && (keyReg == KEY_RESET);
      if (ctrlWr) begin
        keyReg <= regWrData[KEY_LSB +: KEY_W];
        ieReg  <= regWrData[IE_LSB +: NUM_IE];
      end
    end
  end

  assign irq = (|(flags[NUM_IE-1:0] & ieReg)) || (flags[NUM_FLAGS-1] && (keyReg == KEY_IRQ));

  always_comb begin
    unique case (addrE)
      ADDR_HIGH: regRdData = highCfgRd;
      ADDR_LOW:  regRdData = lowCfgRd;
      ADDR_OTP:  regRdData = otpCfgRd;
      default:   regRdData = (32'(flags) << FLAG_LSB) | (32'(keyReg) << KEY_LSB)
                           | (32'(ieReg) << IE_LSB);
    endcase
  end

  AST_NONPERIOD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !periodMode) |=> ((flags & ~$past(flags)) == '0)) // R10
    else $error("flag raised by non-periodic sample");

  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !codeOk) |=> ((flags & ~$past(flags)) == '0)) // R11
    else $error("flag raised by broken code");

  AST_HIGH_RISE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highAct) |-> flags[0]) // R3
    else $error("high alarm active without valid flag");

  AST_LOW_RELEASE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lowAct) && $past(cmp.lowEn)) |-> flags[3]) // R5
    else $error("low alarm released without removed flag");

  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq) // R7
    else $error("reset request longer than one cycle");

  AST_RESET_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(keyReg) == KEY_RESET && flags[NUM_FLAGS-1])) // R7
    else $error("reset request without reset key or overheat flag");

endmodule

// File: rtl/thermal_alarm.sv
module thermal_alarm
  import thermal_alarm_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int HYST        = 3,
  parameter int HI_TRIG_RST = 3000,
  parameter int LO_TRIG_RST = 500,
  parameter int OTP_RST     = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodMode,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq,
  output logic              resetReq
);

  cfgWrT       cfgWr;
  cmpT         cmp;
  logic [31:0] highCfgRd, lowCfgRd, otpCfgRd;

  thermal_alarm_dp #(
    .CODE_W(CODE_W), .HYST(HYST), .HI_TRIG_RST(HI_TRIG_RST),
    .LO_TRIG_RST(LO_TRIG_RST), .OTP_RST(OTP_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .wrData(regWrData), .code(sampleCode),
    .cmp(cmp), .highCfgRd(highCfgRd), .lowCfgRd(lowCfgRd), .otpCfgRd(otpCfgRd)
  );

  thermal_alarm_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodMode(periodMode), .sampleValid(sampleValid),
    .sampleCode(sampleCode), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cmp(cmp), .highCfgRd(highCfgRd), .lowCfgRd(lowCfgRd),
    .otpCfgRd(otpCfgRd), .cfgWr(cfgWr), .regRdData(regRdData), .irq(irq),
    .resetReq(resetReq)
  );

endmodule

// File: tb/thermal_alarm_bench.sv
module thermal_alarm_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        periodMode = 1'b1;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleCode = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd3;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq, resetReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic [3:0] curKey = '0;
  logic [3:0] curIe = '0;

  always #10 clk = ~clk;

  thermal_alarm u_thermal_alarm (
    .clk(clk), .rstN(rstN), .periodMode(periodMode), .sampleValid(sampleValid),
    .sampleCode(sampleCode), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .resetReq(resetReq)
  );

  function automatic logic [31:0] cfgWord(input logic en, input int rel, input int trig);
    return (32'(en) << 31) | (32'(rel) << 16) | 32'(trig);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd3;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 2'd3;
    #1;
  endtask

  task automatic ctl(input logic [4:0] clrMask);
    wr(2'd3, (32'(clrMask) << 24) | (32'(curKey) << 12) | (32'(curIe) << 8));
  endtask

  task automatic smp(input logic [11:0] c);
    @(negedge clk);
    sampleValid = 1'b1; sampleCode = c;
    @(negedge clk);
    sampleValid = 1'b0;
    #1;
  endtask

  function automatic logic [4:0] flagsNow();
    return regRdData[28:24];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 resetReq", 32'(resetReq), 0);
    rd(2'd0, d); chk("R1 high cfg", d, cfgWord(0, 3000 - 3, 3000));
    rd(2'd1, d); chk("R1 low cfg", d, cfgWord(0, 500 + 3, 500));
    rd(2'd2, d); chk("R1 otp cfg", d, 32'd4000);
    rd(2'd3, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R2 otp unlisted bits", d, 32'h8000_0FFF);
    wr(2'd2, 32'd4000);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 high fields", d, 32'h8FFF_0FFF);
    wr(2'd0, cfgWord(1, 2000, 2100));
    rd(2'd0, d); chk("R2 high readback", d, cfgWord(1, 2000, 2100));
    curKey = 4'h3; curIe = 4'b0001;
    ctl(5'h1F);
    rd(2'd3, d); chk("R2 ctrl fields", d, (32'h3 << 12) | (32'h1 << 8));
  endtask

  task automatic t_high();
    smp(12'd1500); chk("R3 below trip", 32'(flagsNow()), 0);
    smp(12'd2100); chk("R3 trip at level", 32'(flagsNow()), 32'h01);
    chk("R8 irq high valid", 32'(irq), 1);
    ctl(5'h01); chk("R9 cleared", 32'(flagsNow()), 0);
    chk("R8 irq drops", 32'(irq), 0);
    smp(12'd2500); chk("R3 no refire", 32'(flagsNow()), 0);
    smp(12'd2050); chk("R4 band hold", 32'(flagsNow()), 0);
    smp(12'd2000); chk("R4 release", 32'(flagsNow()), 32'h02);
    chk("R8 removal not enabled", 32'(irq), 0);
    ctl(5'h02);
    smp(12'd2100); chk("R3 rearmed", 32'(flagsNow()), 32'h01);
    ctl(5'h01);
    wr(2'd0, cfgWord(0, 2000, 2100));
  endtask

  task automatic t_low();
    wr(2'd1, cfgWord(1, 800, 700));
    curIe = 4'b0100; ctl(5'h00);
    smp(12'd750); chk("R5 above trip", 32'(flagsNow()), 0);
    smp(12'd700); chk("R5 low valid", 32'(flagsNow()), 32'h04);
    chk("R8 irq low valid", 32'(irq), 1);
    ctl(5'h04);
    smp(12'd790); chk("R5 band hold", 32'(flagsNow()), 0);
    smp(12'd800); chk("R5 low removed", 32'(flagsNow()), 32'h08);
    chk("R8 no irq w/o enable", 32'(irq), 0);
    curIe = 4'b1000; ctl(5'h00);
    chk("R8 irq after enable", 32'(irq), 1);
    ctl(5'h08);
  endtask

  task automatic t_invalid();
    smp(12'd0); chk("R11 code zero ignored", 32'(flagsNow()), 0);
    wr(2'd0, cfgWord(1, 2000, 2100));
    smp(12'd4095); chk("R11 code max ignored", 32'(flagsNow()), 0);
    smp(12'd4094); chk("R11 next code accepted", 32'(flagsNow()), 32'h01);
    ctl(5'h01);
  endtask

  task automatic t_nonperiodic();
    periodMode = 1'b0;
    smp(12'd600); chk("R10 ignored", 32'(flagsNow()), 0);
    periodMode = 1'b1;
    smp(12'd600); chk("R10 state kept", 32'(flagsNow()), 32'h06);
    ctl(5'h06);
    wr(2'd0, cfgWord(0, 2000, 2100));
    wr(2'd1, cfgWord(0, 800, 700));
  endtask

  task automatic t_disable();
    wr(2'd0, cfgWord(1, 2000, 2100));
    smp(12'd2200); chk("R12 first valid", 32'(flagsNow()), 32'h01);
    ctl(5'h01);
    wr(2'd0, cfgWord(0, 2000, 2100));
    chk("R12 no event on disable", 32'(flagsNow()), 0);
    wr(2'd0, cfgWord(1, 2000, 2100));
    smp(12'd2200); chk("R12 valid again", 32'(flagsNow()), 32'h01);
    ctl(5'h01);
    wr(2'd0, cfgWord(0, 2000, 2100));
  endtask

  task automatic t_otp();
    wr(2'd2, cfgWord(1, 0, 3500));
    curIe = 4'b0000; curKey = 4'h5; ctl(5'h1F);
    smp(12'd3400); chk("R6 below", 32'(flagsNow()), 0);
    smp(12'd3600); chk("R6 overheat flag", 32'(flagsNow()), 32'h10);
    chk("R7 irq key5", 32'(irq), 1);
    chk("R7 no reset key5", 32'(resetReq), 0);
    ctl(5'h10); chk("R8 irq cleared", 32'(irq), 0);
    smp(12'd3700); chk("R6 no refire", 32'(flagsNow()), 0);
    smp(12'd3400); chk("R6 rearm quiet", 32'(flagsNow()), 0);
    curKey = 4'hA; ctl(5'h00);
    smp(12'd3600); chk("R7 reset pulse", 32'(resetReq), 1);
    chk("R7 no irq keyA", 32'(irq), 0);
    chk("R6 flag keyA", 32'(flagsNow()), 32'h10);
    @(negedge clk); chk("R7 pulse ends", 32'(resetReq), 0);
    ctl(5'h10);
    smp(12'd3400);
    curKey = 4'h3; ctl(5'h00);
    smp(12'd3600);
    chk("R7 other key flag", 32'(flagsNow()), 32'h10);
    chk("R7 other key irq", 32'(irq), 0);
    chk("R7 other key reset", 32'(resetReq), 0);
    ctl(5'h10);
    smp(12'd3400);
  endtask

  task automatic t_w1c();
    curKey = 4'h5; ctl(5'h00);
    @(negedge clk);
    sampleValid = 1'b1; sampleCode = 12'd3600;
    regWrEn = 1'b1; regAddr = 2'd3;
    regWrData = (32'h10 << 24) | (32'(curKey) << 12);
    @(negedge clk);
    sampleValid = 1'b0; regWrEn = 1'b0;
    #1;
    chk("R9 set wins", 32'(flagsNow()), 32'h10);
    ctl(5'h00); chk("R9 zero keeps", 32'(flagsNow()), 32'h10);
    ctl(5'h10); chk("R9 one clears", 32'(flagsNow()), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_regs();
    t_high();
    t_low();
    t_invalid();
    t_nonperiodic();
    t_disable();
    t_otp();
    t_w1c();
    finish_run();
  end

endmodule